// File: doc/BRIEF.md
# Serial Teleprinter Character Controller

This block connects a processor accumulator to a current-loop teleprinter. Every character on the line takes eleven unit times: one start space, eight character bits with the least significant bit first, and a stop mark two units long. A mark is line level 1 (current flowing) and a space is line level 0. The transmit half takes an 8-bit word from the accumulator in parallel and sends it as a serial frame. When the stop mark ends, it raises the printer flag. The receive half finds the start space and samples each unit at its midpoint. It assembles the character into a receive register in which a space is stored as 1 and a mark as 0. It raises the keyboard flag when the eighth character bit has been captured.

Software sees the block as two devices: a keyboard, selected by `kbd_sel`, and a printer, selected by `prt_sel`. Three shared command pulses drive both. `iop1` tests the selected device's flag and requests a skip. `iop2` clears the selected flag; on the keyboard it also asks for the accumulator to be cleared. `iop4` starts the transfer. Either flag requests an interrupt. A keyboard read also starts the paper-tape reader. The reader advance output is active only while the reader runs and the keyboard flag is 0. The unit time is `UNIT_CLKS` clock cycles.

The transmitter state machine moves TX_IDLE → TX_START on a printer load. It moves TX_START → TX_DATA after one unit, TX_DATA → TX_STOP after the eighth bit, and TX_STOP → TX_IDLE after two units. The receiver moves RX_IDLE → RX_START on a space. It moves RX_START → RX_DATA at the half-unit point if the line is still a space, and RX_START → RX_IDLE if the line has returned to mark. It moves RX_DATA → RX_STOP after the eighth sample, and RX_STOP → RX_IDLE at a unit end that finds a mark.

Top module: `teleprinter_link`

## Requirements
- R1: After reset, `tx_line` is 1 (mark), `irq` is 0, `reader_adv` is 0, and `skip` is 0 for an `iop1` on either device.
- R2: A printer load (`prt_sel` and `iop4`) sends one frame on `tx_line`, each unit `UNIT_CLKS` cycles long. The frame is a start unit at 0, then bits 0 to 7 of `ac_wr_data` with 1 sent as mark, then two stop units at 1.
- R3: When the second stop unit ends, the printer flag becomes 1. `irq` is then 1, and a printer `iop1` gives `skip` = 1.
- R4: A printer `iop2` clears the printer flag. After it, a printer `iop1` gives `skip` = 0 and `irq` falls to 0 when the keyboard flag is also 0.
- R5: A printer load while a frame is in progress is ignored. The running frame completes unchanged and no second frame follows.
- R6: After a received frame, the keyboard flag is 1 and `irq` is 1. A keyboard `iop4` drives `ac_rd_data`, during the pulse, with the complement of the receive register, which stores space = 1. The result is therefore the character with mark = 1, bit 0 being the first bit received.
- R7: The receiver samples each unit at its midpoint. A space shorter than half a unit in idle raises no flag. A character whose bit edges are corrupted for three cycles at each end of every unit is still received correctly.
- R8: A keyboard `iop1` gives `skip` = 1 only while the keyboard flag is 1. A keyboard `iop2` asserts `ac_clear` during the pulse and clears the keyboard flag.
- R9: A keyboard `iop4` sets the reader-run state, and the start of an incoming character clears it. `reader_adv` equals reader-run AND NOT keyboard flag.
- R10: Command pulses with neither select high have no effect: no skip, no frame sent, no flag change.
- R11: `ac_rd_data` is 0 except during a keyboard `iop4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_sel | input | 1 | Keyboard (input) device selected |
| prt_sel | input | 1 | Printer (output) device selected |
| iop1 | input | 1 | Command pulse: flag skip test |
| iop2 | input | 1 | Command pulse: clear flag / accumulator |
| iop4 | input | 1 | Command pulse: start transfer |
| ac_wr_data | input | CHAR_W | Accumulator word for the printer |
| ac_rd_data | output | CHAR_W | Word gated toward the accumulator |
| ac_clear | output | 1 | Request to clear the accumulator |
| skip | output | 1 | Skip request |
| irq | output | 1 | Interrupt request (either flag) |
| rx_line | input | 1 | Serial line from keyboard/reader, 1 = mark |
| tx_line | output | 1 | Serial line to printer, 1 = mark |
| reader_adv | output | 1 | Paper-tape reader advance enable |

## Verification
Transmit is tried with the words 0x55, 0xA3, 0x00 and 0xFF. The alternating word exposes bit-order and shift errors. The all-zero and all-one words show whether the start and stop units are framed correctly against data of the same level. Receive uses one clean character and one whose unit edges are corrupted, which separates midpoint sampling from edge sampling. A short space glitch separates start validation from plain edge detection. A second load issued mid-frame, and commands with no device selected, must leave the serial output unchanged.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/tpl_tx.sv
module tpl_tx
    import tpl_pkg::*;
#(
    parameter int UNIT_CLKS  = 16,
    parameter int CHAR_W     = 8,
    parameter int STOP_UNITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              line,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
    localparam int BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam int STP_W = (STOP_UNITS > 1) ? $clog2(STOP_UNITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNIT_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAR_W - 1);
    localparam logic [STP_W-1:0] STP_LAST = STP_W'(STOP_UNITS - 1);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [STP_W-1:0]  stp_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              line_q;
    logic              done_q;
    logic              unit_end;

    assign unit_end = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (unit_end) state_d = TX_DATA;
            TX_DATA:  if (unit_end && bit_q == BIT_LAST) state_d = TX_STOP;
            TX_STOP:  if (unit_end && stp_q == STP_LAST) state_d = TX_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            stp_q   <= '0;
            shreg_q <= '0;
            line_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == TX_IDLE || unit_end) cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
            unique case (state_q)
                TX_IDLE: begin
                    line_q <= 1'b1;
                    if (load) begin
                        shreg_q <= load_data;
                        line_q  <= 1'b0;
                        bit_q   <= '0;
                    end
                end
                TX_START: begin
                    if (unit_end) begin
                        line_q  <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                    end
                end
                TX_DATA: begin
                    if (unit_end) begin
                        if (bit_q == BIT_LAST) begin
                            line_q <= 1'b1;
                            stp_q  <= '0;
                        end else begin
                            line_q  <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (unit_end) begin
                        stp_q <= stp_q + 1'b1;
                        if (stp_q == STP_LAST) done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign line = line_q;
    assign busy = (state_q != TX_IDLE);
    assign done = done_q;
endmodule

// File: rtl/tpl_rx.sv
module tpl_rx
    import tpl_pkg::*;
#(
    parameter int UNIT_CLKS = 16,
    parameter int CHAR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic [CHAR_W-1:0] char_reg,
    output logic              char_done,
    output logic              start_seen
);
    localparam int CNT_W     = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
    localparam int BIT_W     = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam int HALF_CLKS = (UNIT_CLKS > 1) ? UNIT_CLKS / 2 : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(UNIT_CLKS - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(CHAR_W - 1);

    rx_state_t         state_q, state_d;
    logic [1:0]        sync_q;
    logic              line_s;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CHAR_W-1:0] shreg_q;
    logic [CHAR_W-1:0] char_q;
    logic              done_q;
    logic              start_q;
    logic              unit_end;

    assign line_s   = sync_q[1];
    assign unit_end = (cnt_q == CNT_LAST);

    // two-flop synchronizer, rests at mark
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!line_s) state_d = RX_START;
            RX_START: if (cnt_q == HALF_LAST) state_d = line_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (unit_end && bit_q == BIT_LAST) state_d = RX_STOP;
            RX_STOP:  if (unit_end && line_s) state_d = RX_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            char_q  <= '0;
            done_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            start_q <= (state_q == RX_IDLE) && !line_s;
            if (state_q == RX_IDLE || state_q != state_d || unit_end) cnt_q <= '0;
            else                                                      cnt_q <= cnt_q + 1'b1;
            unique case (state_q)
                RX_IDLE:  bit_q <= '0;
                RX_START: bit_q <= '0;
                RX_DATA: begin
                    if (unit_end) begin
                        // space is stored as 1, first bit lands in bit 0
                        shreg_q <= {~line_s, shreg_q[CHAR_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == BIT_LAST) begin
                            char_q <= {~line_s, shreg_q[CHAR_W-1:1]};
                            done_q <= 1'b1;
                        end
                    end
                end
                RX_STOP: bit_q <= '0;
            endcase
        end
    end

    assign char_reg   = char_q;
    assign char_done  = done_q;
    assign start_seen = start_q;
endmodule

// File: rtl/teleprinter_link.sv
module teleprinter_link #(
    parameter int UNIT_CLKS  = 16,
    parameter int CHAR_W     = 8,
    parameter int STOP_UNITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_sel,
    input  logic              prt_sel,
    input  logic              iop1,
    input  logic              iop2,
    input  logic              iop4,
    input  logic [CHAR_W-1:0] ac_wr_data,
    output logic [CHAR_W-1:0] ac_rd_data,
    output logic              ac_clear,
    output logic              skip,
    output logic              irq,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              reader_adv
);
    logic              tx_load, tx_busy, tx_done;
    logic [CHAR_W-1:0] rx_char;
    logic              rx_done, rx_start;
    logic              in_flag_q, out_flag_q, rdr_run_q;

    assign tx_load = prt_sel && iop4;

    tpl_tx #(
        .UNIT_CLKS (UNIT_CLKS),
        .CHAR_W    (CHAR_W),
        .STOP_UNITS(STOP_UNITS)
    ) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_data(ac_wr_data),
        .line     (tx_line),
        .busy     (tx_busy),
        .done     (tx_done)
    );

    tpl_rx #(
        .UNIT_CLKS(UNIT_CLKS),
        .CHAR_W   (CHAR_W)
    ) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_line),
        .char_reg  (rx_char),
        .char_done (rx_done),
        .start_seen(rx_start)
    );

    // flags: a completion wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flag_q  <= 1'b0;
            out_flag_q <= 1'b0;
            rdr_run_q  <= 1'b0;
        end else begin
            if (rx_done)                  in_flag_q <= 1'b1;
            else if (kbd_sel && iop2)     in_flag_q <= 1'b0;
            if (tx_done)                  out_flag_q <= 1'b1;
            else if (prt_sel && iop2)     out_flag_q <= 1'b0;
            if (rx_start)                 rdr_run_q <= 1'b0;
            else if (kbd_sel && iop4)     rdr_run_q <= 1'b1;
        end
    end

    assign skip       = iop1 && ((kbd_sel && in_flag_q) || (prt_sel && out_flag_q));
    assign ac_clear   = kbd_sel && iop2;
    assign ac_rd_data = (kbd_sel && iop4) ? ~rx_char : '0;
    assign irq        = in_flag_q || out_flag_q;
    assign reader_adv = rdr_run_q && !in_flag_q;
endmodule

// File: rtl/tpl_checker.sv
module tpl_checker #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kbd_sel,
    input logic              prt_sel,
    input logic              iop1,
    input logic              iop2,
    input logic              iop4,
    input logic              skip,
    input logic [CHAR_W-1:0] ac_rd_data,
    input logic              reader_adv,
    input logic              tx_line,
    input logic              in_flag,
    input logic              out_flag,
    input logic              tx_busy,
    input logic              tx_done
);
    a_r10_skip_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbd_sel && !prt_sel) |-> !skip);

    a_r11_rd_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_sel && iop4) |-> (ac_rd_data == '0));

    a_r9_adv_blocked_by_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_flag |-> !reader_adv);

    a_r2_idle_line_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    a_r3_flag_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> out_flag);

    a_r4_printer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (prt_sel && iop2 && !tx_done) |=> !out_flag);

    a_r8_kbd_skip_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_sel && !prt_sel && iop1) |-> (skip == in_flag));

    a_r5_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_done && $past(tx_busy) && prt_sel && iop4) |=> (tx_busy || tx_done));
endmodule

bind teleprinter_link tpl_checker #(.CHAR_W(CHAR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .kbd_sel   (kbd_sel),
    .prt_sel   (prt_sel),
    .iop1      (iop1),
    .iop2      (iop2),
    .iop4      (iop4),
    .skip      (skip),
    .ac_rd_data(ac_rd_data),
    .reader_adv(reader_adv),
    .tx_line   (tx_line),
    .in_flag   (in_flag_q),
    .out_flag  (out_flag_q),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done)
);

// File: tb/teleprinter_link_tb_top.sv
module teleprinter_link_tb_top;
    localparam int UNIT = 16;
    localparam int HALF = UNIT / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_sel = 1'b0, prt_sel = 1'b0;
    logic       iop1 = 1'b0, iop2 = 1'b0, iop4 = 1'b0;
    logic [7:0] ac_wr_data = '0;
    logic [7:0] ac_rd_data;
    logic       ac_clear, skip, irq, tx_line, reader_adv;
    logic       rx_line = 1'b1;

    int n_checks = 0;
    int n_err = 0;
    int frames_seen = 0;
    logic [7:0] exp_q[$];

    always #2.5ns clk = ~clk;

    teleprinter_link #(.UNIT_CLKS(UNIT), .CHAR_W(8), .STOP_UNITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .kbd_sel(kbd_sel), .prt_sel(prt_sel),
        .iop1(iop1), .iop2(iop2), .iop4(iop4), .ac_wr_data(ac_wr_data),
        .ac_rd_data(ac_rd_data), .ac_clear(ac_clear), .skip(skip), .irq(irq),
        .rx_line(rx_line), .tx_line(tx_line), .reader_adv(reader_adv)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic cmd(input logic k, input logic p, input logic c1, input logic c2,
                       input logic c4, input logic [7:0] wd,
                       output logic sk, output logic [7:0] rd, output logic clr);
        @(posedge clk); #1ns;
        kbd_sel = k; prt_sel = p; iop1 = c1; iop2 = c2; iop4 = c4; ac_wr_data = wd;
        @(negedge clk);
        sk = skip; rd = ac_rd_data; clr = ac_clear;
        @(posedge clk); #1ns;
        kbd_sel = 0; prt_sel = 0; iop1 = 0; iop2 = 0; iop4 = 0;
    endtask

    task automatic wait_units(input int n);
        repeat (n * UNIT) @(posedge clk);
    endtask

    // drive one frame; mark = 1 for a 1 bit; corrupt flips 3 cycles at each unit edge
    task automatic send_rx(input logic [7:0] c, input bit corrupt);
        logic v;
        for (int u = 0; u < 11; u++) begin
            v = (u == 0) ? 1'b0 : (u <= 8) ? c[u-1] : 1'b1;
            for (int t = 0; t < UNIT; t++) begin
                @(posedge clk); #1ns;
                if (corrupt && u >= 1 && u <= 8 && (t < 3 || t >= UNIT - 3)) rx_line = ~v;
                else rx_line = v;
            end
        end
        @(posedge clk); #1ns; rx_line = 1'b1;
    endtask

    // scoreboard monitor: decode every frame on tx_line and compare with the queue
    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        logic       st, sp1, sp2;
        @(posedge rst_n);
        forever begin
            @(negedge tx_line);
            repeat (HALF) @(negedge clk);
            st = tx_line;
            for (int i = 0; i < 8; i++) begin
                repeat (UNIT) @(negedge clk);
                got[i] = tx_line;
            end
            repeat (UNIT) @(negedge clk); sp1 = tx_line;
            repeat (UNIT) @(negedge clk); sp2 = tx_line;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R10 unexpected frame on tx_line", int'(got), 0);
            end else begin
                exp = exp_q.pop_front();
                chk(st == 1'b0, "R2 start unit is space", int'(st), 0);
                chk(got == exp, "R2 data bits LSB first", int'(got), int'(exp));
                chk(sp1 && sp2, "R2 two stop units are mark", int'({sp1, sp2}), 3);
            end
            frames_seen++;
        end
    end

    // watchdog
    initial begin
        #(200000 * 5ns);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic       sk, clr;
        logic [7:0] rd;
        int         seen;
        repeat (4) @(posedge clk);
        #1ns rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 tx_line mark after reset", int'(tx_line), 1);
        chk(irq == 1'b0, "R1 irq low after reset", int'(irq), 0);
        chk(reader_adv == 1'b0, "R1 reader_adv low after reset", int'(reader_adv), 0);
        cmd(1, 1, 1, 0, 0, 8'h00, sk, rd, clr);
        chk(sk == 1'b0, "R1 no skip after reset", int'(sk), 0);

        // R2/R3/R4 transmit several patterns
        foreach (exp_q[i]) ;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] w;
            w = (k == 0) ? 8'h55 : (k == 1) ? 8'hA3 : (k == 2) ? 8'h00 : 8'hFF;
            exp_q.push_back(w);
            seen = frames_seen;
            cmd(0, 1, 0, 0, 1, w, sk, rd, clr);
            chk(rd == 8'h00, "R11 rd_data zero on printer load", int'(rd), 0);
            wait (frames_seen == seen + 1);
            wait_units(1);
            cmd(0, 1, 1, 0, 0, 8'h00, sk, rd, clr);
            chk(sk == 1'b1, "R3 printer skip after frame", int'(sk), 1);
            chk(irq == 1'b1, "R3 irq with printer flag", int'(irq), 1);
            cmd(0, 1, 0, 1, 0, 8'h00, sk, rd, clr);
            cmd(0, 1, 1, 0, 0, 8'h00, sk, rd, clr);
            chk(sk == 1'b0, "R4 printer skip cleared", int'(sk), 0);
            chk(irq == 1'b0, "R4 irq low after clear", int'(irq), 0);
        end

        // R5 load during a frame is ignored
        exp_q.push_back(8'h3C);
        seen = frames_seen;
        cmd(0, 1, 0, 0, 1, 8'h3C, sk, rd, clr);
        wait_units(3);
        cmd(0, 1, 0, 0, 1, 8'hC3, sk, rd, clr);
        wait (frames_seen == seen + 1);
        wait_units(13);
        chk(frames_seen == seen + 1, "R5 no second frame after busy load", frames_seen - seen, 1);
        chk(tx_line == 1'b1, "R5 line back at mark", int'(tx_line), 1);
        cmd(0, 1, 0, 1, 0, 8'h00, sk, rd, clr);

        // R10 commands without a select
        seen = frames_seen;
        cmd(0, 0, 1, 1, 1, 8'h81, sk, rd, clr);
        chk(sk == 1'b0, "R10 no skip without select", int'(sk), 0);
        chk(clr == 1'b0, "R10 no ac_clear without select", int'(clr), 0);
        wait_units(13);
        chk(frames_seen == seen, "R10 no frame without select", frames_seen - seen, 0);
        chk(irq == 1'b0, "R10 no flag without select", int'(irq), 0);

        // R6 receive a clean character
        send_rx(8'h5A, 1'b0);
        chk(irq == 1'b1, "R6 irq after received frame", int'(irq), 1);
        cmd(1, 0, 1, 0, 0, 8'h00, sk, rd, clr);
        chk(sk == 1'b1, "R8 keyboard skip with flag", int'(sk), 1);
        cmd(0, 1, 1, 0, 0, 8'h00, sk, rd, clr);
        chk(sk == 1'b0, "R10 printer skip ignores keyboard flag", int'(sk), 0);
        cmd(1, 0, 0, 0, 1, 8'h00, sk, rd, clr);
        chk(rd == 8'h5A, "R6 complemented read gives character", int'(rd), 'h5A);
        @(negedge clk);
        chk(ac_rd_data == 8'h00, "R11 rd_data zero after read", int'(ac_rd_data), 0);
        chk(reader_adv == 1'b0, "R9 advance blocked while flag set", int'(reader_adv), 0);
        cmd(1, 0, 0, 1, 0, 8'h00, sk, rd, clr);
        chk(clr == 1'b1, "R8 ac_clear on keyboard clear", int'(clr), 1);
        @(negedge clk);
        chk(reader_adv == 1'b1, "R9 advance once flag cleared", int'(reader_adv), 1);
        cmd(1, 0, 1, 0, 0, 8'h00, sk, rd, clr);
        chk(sk == 1'b0, "R8 keyboard skip after clear", int'(sk), 0);

        // R9 start of a character stops the reader; R7 corrupted edges
        fork
            send_rx(8'hC6, 1'b1);
            begin
                wait_units(1);
                @(negedge clk);
                chk(reader_adv == 1'b0, "R9 start clears reader run", int'(reader_adv), 0);
            end
        join
        cmd(1, 0, 0, 0, 1, 8'h00, sk, rd, clr);
        chk(rd == 8'hC6, "R7 midpoint sampling of corrupted edges", int'(rd), 'hC6);
        cmd(1, 0, 0, 1, 0, 8'h00, sk, rd, clr);

        // R7 short space in idle is rejected
        @(posedge clk); #1ns rx_line = 1'b0;
        repeat (3) @(posedge clk);
        #1ns rx_line = 1'b1;
        wait_units(12);
        cmd(1, 0, 1, 0, 0, 8'h00, sk, rd, clr);
        chk(sk == 1'b0, "R7 glitch raises no flag", int'(sk), 0);
        chk(irq == 1'b0, "R7 irq stays low after glitch", int'(irq), 0);

        send_rx(8'h01, 1'b0);
        cmd(1, 0, 0, 0, 1, 8'h00, sk, rd, clr);
        chk(rd == 8'h01, "R6 first received bit lands in bit 0", int'(rd), 1);

        finish_run();
    end
endmodule